// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block keeps recent copies of the frequency control word that drives a numerically controlled oscillator, so the oscillator can keep running at a known frequency after its reference is lost. While the loop is tracking, meaning it is locked and not in holdover, a millisecond tick drives a period counter. Each time the counter reaches the store period, the live word is written into one of two storage slots. The slots are used in turn.

When holdover is requested, the block stops all writes. It then drives out the slot that was not written last, which is the older of the two samples. That word is between one and two store periods old. Any disturbance in the last period before the reference was lost therefore does not reach the held frequency. If both slots have not yet been filled since the loop last locked, a nominal centre word is driven instead. Outside holdover the output simply follows the live word.

The block does no loop filtering and makes no mode decisions. Its inputs are the live word, the tick, the lock flag and the holdover request.

Top module: `hold_word_store`

## Requirements
- R1: While tracking (lock_i high and hold_i low), the live word is stored once every PERIOD_MS ticks, on the PERIOD_MS-th tick counted since tracking began. Successive stores go to the two slots in turn.
- R2: When lock_i is low and hold_i is low, nothing is stored and the tick counter is cleared. The first store after lock returns needs a full PERIOD_MS ticks.
- R3: While hold_i is high and fill_ok_o is high, word_o equals the older stored sample. That is the live word captured at the next-to-last store, taken between PERIOD_MS and 2*PERIOD_MS ticks before holdover began.
- R4: While hold_i is high, no slot is written, whatever ticks or live words arrive. word_o stays constant for the whole holdover.
- R5: fill_ok_o goes high only after two stores since the fill count was last cleared. While hold_i is high and fill_ok_o is low, word_o equals CENTER_WORD.
- R6: While hold_i is low, word_o equals live_word_i in the same cycle.
- R7: After hold_i falls, fill_ok_o is low and the tick counter starts again from zero. fill_ok_o returns only after 2*PERIOD_MS further tracking ticks.
- R8: After reset, fill_ok_o is low and word_o follows live_word_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| live_word_i | input | WORD_W | Live oscillator frequency control word |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| lock_i | input | 1 | Loop locked to its reference |
| hold_i | input | 1 | Holdover request |
| word_o | output | WORD_W | Word for the oscillator |
| fill_ok_o | output | 1 | Both slots hold samples taken since the last lock |

## Verification
The case hardest to reach from the ports is entering holdover at every phase of the ping-pong cycle. That means zero, one, two or more stores completed, and every tick offset within a period, while the live word changes on each tick. Only then does a wrong slot choice, or an off-by-one in the period, show up as a distinct value. The bench sweeps the number of tracking ticks before holdover across several full periods, with a small period and a live word that is a known linear function of the tick index, and computes the expected held word arithmetically. Each case then drives ticks during holdover and releases it, to cover write blocking and the restarted fill count.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_BOTH = 2'd2
  } fill_e;

  function automatic fill_e fill_next(input fill_e cur);
    case (cur)
      FILL_NONE: fill_next = FILL_ONE;
      default:   fill_next = FILL_BOTH;
    endcase
  endfunction
endpackage

// File: rtl/hws_period_timer.sv
module hws_period_timer #(
  parameter int unsigned PERIOD_MS = 30,
  localparam int unsigned CNT_W = (PERIOD_MS > 1) ? $clog2(PERIOD_MS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic track_i,
  input  logic tick_i,
  output logic sample_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_MS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap     = (cnt_q == LAST);
  assign sample_o = track_i & tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!track_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R1
  AST_CNT_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(track_i) |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/hws_slot_bank.sv
module hws_slot_bank
  import hws_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              hold_i,
  input  logic              sample_i,
  input  logic [WORD_W-1:0] live_i,
  output logic [WORD_W-1:0] old_word_o,
  output logic              full_o
);
  logic [WORD_W-1:0] slot_q [2];
  logic              last_q;
  logic              hold_q;
  fill_e             fill_q;
  logic              wr_sel;
  logic              clear;

  assign wr_sel = ~last_q;
  assign clear  = (!lock_i && !hold_i) || (hold_q && !hold_i);

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[s] <= '0;
      end else if (sample_i && !hold_i && (wr_sel == 1'(s))) begin
        slot_q[s] <= live_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b1;
      hold_q <= 1'b0;
      fill_q <= FILL_NONE;
    end else begin
      hold_q <= hold_i;
      if (sample_i && !hold_i) last_q <= wr_sel;
      if (clear) begin
        fill_q <= (sample_i && !hold_i) ? FILL_ONE : FILL_NONE;
      end else if (sample_i && !hold_i) begin
        fill_q <= fill_next(fill_q);
      end
    end
  end

  // the slot not written last holds the older sample
  assign old_word_o = slot_q[~last_q];
  assign full_o     = (fill_q == FILL_BOTH);

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> ($stable(slot_q[0]) && $stable(slot_q[1]) && $stable(last_q))); // R4
  AST_PTR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !hold_i) |=> (last_q != $past(last_q))); // R1
  AST_FILL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_BOTH); // R5
endmodule

// File: rtl/hws_out_mux.sv
module hws_out_mux #(
  parameter int unsigned       WORD_W      = 24,
  parameter logic [WORD_W-1:0] CENTER_WORD = '0
) (
  input  logic              hold_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] live_i,
  input  logic [WORD_W-1:0] old_word_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    if (!hold_i)     word_o = live_i;
    else if (full_i) word_o = old_word_i;
    else             word_o = CENTER_WORD;
  end
endmodule

// File: rtl/hold_word_store.sv
module hold_word_store #(
  parameter int unsigned       WORD_W      = 24,
  parameter int unsigned       PERIOD_MS   = 30,
  parameter logic [WORD_W-1:0] CENTER_WORD = WORD_W'(1) << (WORD_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] live_word_i,
  input  logic              ms_tick_i,
  input  logic              lock_i,
  input  logic              hold_i,
  output logic [WORD_W-1:0] word_o,
  output logic              fill_ok_o
);
  logic              track;
  logic              sample;
  logic [WORD_W-1:0] old_word;
  logic              full;

  assign track = lock_i & ~hold_i;

  hws_period_timer #(.PERIOD_MS(PERIOD_MS)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .track_i (track),
    .tick_i  (ms_tick_i),
    .sample_o(sample)
  );

  hws_slot_bank #(.WORD_W(WORD_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (lock_i),
    .hold_i    (hold_i),
    .sample_i  (sample),
    .live_i    (live_word_i),
    .old_word_o(old_word),
    .full_o    (full)
  );

  hws_out_mux #(.WORD_W(WORD_W), .CENTER_WORD(CENTER_WORD)) i_mux (
    .hold_i    (hold_i),
    .full_i    (full),
    .live_i    (live_word_i),
    .old_word_i(old_word),
    .word_o    (word_o)
  );

  assign fill_ok_o = full;

  AST_VALID_NEEDS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_ok_o) |-> $past(sample)); // R5
  AST_HOLD_WORD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> $stable(word_o)); // R4
endmodule

// File: tb/test_hold_word_store.sv
module test_hold_word_store;
  localparam int unsigned W = 8;
  localparam int unsigned P = 3;
  localparam logic [W-1:0] CENTER = 8'h80;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] live = '0;
  logic         tick = 1'b0;
  logic         lock = 1'b0;
  logic         hold = 1'b0;
  logic [W-1:0] word;
  logic         fill_ok;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hold_word_store #(.WORD_W(W), .PERIOD_MS(P), .CENTER_WORD(CENTER)) i_hold_word_store (
    .clk_i(clk), .rst_ni(rst_n), .live_word_i(live), .ms_tick_i(tick),
    .lock_i(lock), .hold_i(hold), .word_o(word), .fill_ok_o(fill_ok)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_once(input logic [W-1:0] w);
    @(negedge clk); live = w; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    live = 8'h5a;
    @(negedge clk);
    chk("R8 fill_ok after reset", W'(fill_ok), 0);
    chk("R8 word after reset", word, 8'h5a);
    rst_n = 1'b1;

    for (int n = 0; n <= 13; n++) begin
      logic [W-1:0] base, exp_w, held;
      int k;
      base = W'(n * 16 + 1);
      lock = 1'b0; hold = 1'b0;
      repeat (2) @(negedge clk);
      // R2: ticks while unlocked must not store
      for (int t = 0; t < 2 * P; t++) tick_once(8'hee);
      chk("R2 no store while unlocked", W'(fill_ok), 0);
      lock = 1'b1;
      for (int t = 1; t <= n; t++) begin
        tick_once(base + W'(7 * t));
        chk("R6 live passthrough", word, base + W'(7 * t));
      end
      k = n / P;
      exp_w = (k >= 2) ? base + W'(7 * P * (k - 1)) : CENTER;
      @(negedge clk); hold = 1'b1;
      @(negedge clk);
      chk((k >= 2) ? "R3 older slot held" : "R5 center word held", word, exp_w);
      chk("R5 fill_ok vs stores", W'(fill_ok), W'(k >= 2));
      held = word;
      for (int t = 0; t < 2 * P; t++) tick_once(8'h33 + W'(t));
      chk("R4 holdover word frozen", word, held);
      chk("R4 fill_ok frozen", W'(fill_ok), W'(k >= 2));
      @(negedge clk); hold = 1'b0; live = 8'h11;
      @(negedge clk);
      chk("R6 live after release", word, 8'h11);
      chk("R7 fill_ok cleared on release", W'(fill_ok), 0);
      if (n % 4 == 0) begin
        for (int t = 1; t < 2 * P; t++) tick_once(8'h40 + W'(t));
        chk("R7 not refilled one tick early", W'(fill_ok), 0);
        tick_once(8'h40 + W'(2 * P));
        chk("R1 refilled after two periods", W'(fill_ok), 1);
        @(negedge clk); hold = 1'b1;
        @(negedge clk);
        chk("R1 alternate slot after refill", word, 8'h40 + W'(P));
        hold = 1'b0;
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule